// File: doc/BRIEF.md
# Diagnostic Alarm Interrupt Latch Bank

This block gathers the alarm and warning flags of a transceiver's diagnostic monitor into one interrupt line. There are five monitored quantities: temperature, supply voltage, laser bias current, transmit power and receive power. Each has a high and a low condition, which gives ten alarm flags and ten warning flags. The host picks which flags may raise the interrupt by setting enable bits. When an enabled flag is active, the block latches it into a sticky latch bit and holds the fault line high until the host clears every latch. With this scheme the host does not have to poll the monitor.

The host reaches the bank through a byte port. A start strobe loads an 8-bit offset pointer, and each byte read or written after that moves the pointer up by one, so several bytes can go in one burst. The four enable bytes live at offsets 248 to 251. The four latch bytes live at offsets 252 to 255. The flag inputs come from an existing monitor. They follow the byte layout of the status bytes at 112/113 (alarms) and 116/117 (warnings).

Top module: `diag_irq_bank`

## Requirements
- R1: After reset every enable and latch bit is 0, `fault_o` is 0, `rd_data` is 0 and the pointer is 0.
- R2: Bit layout. Enable bytes 248 and 249 are for alarms and 250 and 251 are for warnings. In the first byte of each pair, bit 7 down to bit 0 is: temperature high, temperature low, voltage high, voltage low, bias high, bias low, transmit power high, transmit power low. In the second byte, bit 7 is receive power high, bit 6 is receive power low, and bits 5..0 are reserved. The flag inputs `alarm_stat`/`warn_stat` carry the first byte in [15:8] and the second in [7:0], with the same bit positions. Reserved bits read 0, ignore writes and never latch.
- R3: A latch bit (bytes 252..255 mirror 248..251 bit for bit) becomes 1 at the clock edge where its enable bit is 1 and its flag input is 1. Latching is level based and uses the enable value held before that edge.
- R4: A set latch bit stays 1 when its flag goes inactive or its enable is cleared. A flag whose enable is 0 never sets its latch.
- R5: Writing 1 to a latch bit clears it, and writing 0 has no effect. The bit is re-evaluated in the same cycle, so it stays 1 if its flag is still active and enabled.
- R6: `fault_o` is 1 exactly while at least one latch bit is 1. It rises in the cycle after the latching edge and falls in the cycle after the clearing write.
- R7: Each accepted read or write moves the pointer up by one. Offset 255 is followed by offset 0.
- R8: Offsets outside 248..255 read as 0, and writes to them change nothing.
- R9: When `start_vld` is high, the pointer loads `start_ofs` and any read or write in that cycle is ignored. When `wr_vld` and `rd_vld` are both high, only the write takes place.
- R10: `rd_data` takes the byte at the pointer on the edge where a read is accepted. It holds its value at every other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alarm_stat | input | 16 | Alarm flags, [15:8] = byte 112, [7:0] = byte 113 |
| warn_stat | input | 16 | Warning flags, [15:8] = byte 116, [7:0] = byte 117 |
| start_vld | input | 1 | Load the pointer from `start_ofs` |
| start_ofs | input | 8 | Start offset of a burst |
| wr_vld | input | 1 | Write `wr_data` at the pointer |
| wr_data | input | 8 | Write byte |
| rd_vld | input | 1 | Read the byte at the pointer |
| rd_data | output | 8 | Registered read byte |
| fault_o | output | 1 | Interrupt/fault line, high while any latch is set |

## Verification
The assertions check the following on every cycle:
- An enabled, active flag always leads to `fault_o` one cycle later.
- A latch bit never drops without a clear write, and never rises without an enabled, active flag.
- The fault line only falls after an accepted write.
- The pointer follows its load and wrap rules.
- `rd_data` holds between accepted reads.

Some behaviours show up only through the bench's scenarios:
- The exact bit mapping of each quantity.
- The re-evaluation of a latch whose flag is still active when it is cleared.
- Writes to unimplemented offsets doing nothing.
- The full 255-to-0 wrap that lands a later burst byte back on offset 248.

// File: rtl/diag_irq_pkg.sv
// Package: shared constants and helpers for the diagnostic interrupt bank.
// Assumes byte-wide registers and conditions packed from bit 7 downwards.
package diag_irq_pkg;
    localparam int BYTE_W = 8;

    // Mask of the implemented bits in one byte of a kind (alarm or warning).
    // Condition n of a kind sits in byte n/8, at bit 7-(n%8).
    function automatic logic [BYTE_W-1:0] valid_mask(int unsigned byte_in_kind,
                                                     int unsigned n_cond);
        logic [BYTE_W-1:0] m;
        m = '0;
        for (int unsigned b = 0; b < BYTE_W; b++) begin
            if ((byte_in_kind * BYTE_W + b) < n_cond)
                m[BYTE_W-1-b] = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/dib_offset_ptr.sv
// Module: burst offset pointer.
// The pointer loads on a start strobe and otherwise steps by one on each
// accepted access. Wrap-around is the natural overflow of AW bits.
// Assumes load and adv are never high together (the top resolves priority).
module dib_offset_ptr #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          adv,
    output logic [AW-1:0] ptr
);
    // Pointer register: load, step or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (load)
            ptr <= load_val;
        else if (adv)
            ptr <= ptr + AW'(1);
    end
endmodule

// File: rtl/dib_enable_regs.sv
// Module: interrupt enable bytes, one register per byte. Reserved bits are
// masked on write, so they always read 0.
// Assumes the first N_BYTES/2 bytes are alarms and the rest are warnings.
module dib_enable_regs
    import diag_irq_pkg::*;
#(
    parameter int N_BYTES = 4,
    parameter int N_COND  = 10
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [N_BYTES-1:0]             wr_sel,
    input  logic [BYTE_W-1:0]              wdata,
    output logic [N_BYTES-1:0][BYTE_W-1:0] en_q
);
    localparam int BPK = N_BYTES / 2;

    for (genvar k = 0; k < N_BYTES; k++) begin : g_byte
        localparam logic [BYTE_W-1:0] MASK = valid_mask(k % BPK, N_COND);
        // Enable byte k: write masked data when selected.
        always_ff @(posedge clk) begin
            if (!rst_n)
                en_q[k] <= '0;
            else if (wr_sel[k])
                en_q[k] <= wdata & MASK;
        end
    end
endmodule

// File: rtl/dib_latch_cells.sv
// Module: sticky latch bytes.
// A bit sets while its enable and flag are both 1, and is cleared by a 1 in
// the clear byte. Set wins over clear in the same cycle, which gives the
// re-evaluation after a clear. Also reduces all latches to the fault line.
// Assumes clr is already qualified by the write decode.
module dib_latch_cells
    import diag_irq_pkg::*;
#(
    parameter int N_BYTES = 4,
    parameter int N_COND  = 10
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [N_BYTES-1:0][BYTE_W-1:0] en,
    input  logic [N_BYTES-1:0][BYTE_W-1:0] stat,
    input  logic [N_BYTES-1:0][BYTE_W-1:0] clr,
    output logic [N_BYTES-1:0][BYTE_W-1:0] lat_q,
    output logic                           any_set
);
    localparam int BPK = N_BYTES / 2;

    for (genvar k = 0; k < N_BYTES; k++) begin : g_byte
        localparam logic [BYTE_W-1:0] MASK = valid_mask(k % BPK, N_COND);
        logic [BYTE_W-1:0] nxt;
        // Next latch byte: keep the bits not cleared, then add the live sources.
        always_comb nxt = ((lat_q[k] & ~clr[k]) | (en[k] & stat[k])) & MASK;
        // Latch byte register.
        always_ff @(posedge clk) begin
            if (!rst_n)
                lat_q[k] <= '0;
            else
                lat_q[k] <= nxt;
        end
    end

    // Fault line: any latch bit set.
    always_comb any_set = |lat_q;
endmodule

// File: rtl/dib_read_port.sv
// Module: read decode and registered read data.
// Enable bytes sit at BASE_OFS.., latch bytes follow them, and every other
// offset reads 0. Assumes rd_acc has already lost priority to start/write.
module dib_read_port
    import diag_irq_pkg::*;
#(
    parameter int AW       = 8,
    parameter int BASE_OFS = 248,
    parameter int N_BYTES  = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           rd_acc,
    input  logic [AW-1:0]                  ptr,
    input  logic [N_BYTES-1:0][BYTE_W-1:0] en,
    input  logic [N_BYTES-1:0][BYTE_W-1:0] lat,
    output logic [BYTE_W-1:0]              rd_data
);
    logic [BYTE_W-1:0] sel;

    // Byte select: match the pointer against each implemented offset.
    always_comb begin
        sel = '0;
        for (int k = 0; k < N_BYTES; k++) begin
            if (ptr == AW'(BASE_OFS + k))
                sel = en[k];
            if (ptr == AW'(BASE_OFS + N_BYTES + k))
                sel = lat[k];
        end
    end

    // Read data register: capture on an accepted read, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (rd_acc)
            rd_data <= sel;
    end
endmodule

// File: rtl/diag_irq_bank.sv
// Module: diagnostic alarm/warning interrupt latch bank (top).
// Host byte port with an auto-incrementing pointer. Enable bytes sit at
// BASE_OFS.., latch bytes right after them, and fault_o is high while any
// latch is set. Priority: start beats write, and write beats read.
// Assumes flag inputs are synchronous to clk.
module diag_irq_bank
    import diag_irq_pkg::*;
#(
    parameter int AW       = 8,
    parameter int BASE_OFS = 248,
    parameter int N_COND   = 10
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [((N_COND+7)/8)*BYTE_W-1:0]  alarm_stat,
    input  logic [((N_COND+7)/8)*BYTE_W-1:0]  warn_stat,
    input  logic                              start_vld,
    input  logic [AW-1:0]                     start_ofs,
    input  logic                              wr_vld,
    input  logic [BYTE_W-1:0]                 wr_data,
    input  logic                              rd_vld,
    output logic [BYTE_W-1:0]                 rd_data,
    output logic                              fault_o
);
    localparam int BPK      = (N_COND + 7) / 8;
    localparam int N_BYTES  = 2 * BPK;
    localparam int LAT_BASE = BASE_OFS + N_BYTES;

    logic                           wr_acc;
    logic                           rd_acc;
    logic [AW-1:0]                  ptr;
    logic [N_BYTES-1:0]             en_wsel;
    logic [N_BYTES-1:0][BYTE_W-1:0] en_q;
    logic [N_BYTES-1:0][BYTE_W-1:0] lat_q;
    logic [N_BYTES-1:0][BYTE_W-1:0] stat_b;
    logic [N_BYTES-1:0][BYTE_W-1:0] clr_b;

    // Access qualification: start wins, then write, then read.
    always_comb begin
        wr_acc = wr_vld && !start_vld;
        rd_acc = rd_vld && !wr_vld && !start_vld;
    end

    for (genvar k = 0; k < N_BYTES; k++) begin : g_map
        // Write decode for the enable byte and the latch clear byte.
        assign en_wsel[k] = wr_acc && (ptr == AW'(BASE_OFS + k));
        assign clr_b[k]   = (wr_acc && (ptr == AW'(LAT_BASE + k))) ? wr_data : '0;
        // Flag byte k: alarm bytes first, then warning bytes, high byte first.
        if (k < BPK) begin : g_alarm
            assign stat_b[k] = alarm_stat[(BPK-1-k)*BYTE_W +: BYTE_W];
        end else begin : g_warn
            assign stat_b[k] = warn_stat[(N_BYTES-1-k)*BYTE_W +: BYTE_W];
        end
    end

    dib_offset_ptr #(.AW(AW)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start_vld),
        .load_val (start_ofs),
        .adv      (wr_acc || rd_acc),
        .ptr      (ptr)
    );

    dib_enable_regs #(.N_BYTES(N_BYTES), .N_COND(N_COND)) u_en (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_sel (en_wsel),
        .wdata  (wr_data),
        .en_q   (en_q)
    );

    dib_latch_cells #(.N_BYTES(N_BYTES), .N_COND(N_COND)) u_lat (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en_q),
        .stat    (stat_b),
        .clr     (clr_b),
        .lat_q   (lat_q),
        .any_set (fault_o)
    );

    dib_read_port #(.AW(AW), .BASE_OFS(BASE_OFS), .N_BYTES(N_BYTES)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_acc  (rd_acc),
        .ptr     (ptr),
        .en      (en_q),
        .lat     (lat_q),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/diag_irq_bank_chk.sv
// Module: protocol and latch checker, bound to diag_irq_bank.
// Relates enable, flag, latch and port state across cycles.
module diag_irq_bank_chk #(
    parameter int AW = 8,
    parameter int W  = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_vld,
    input logic [AW-1:0] start_ofs,
    input logic          wr_vld,
    input logic          rd_vld,
    input logic [AW-1:0] ptr,
    input logic [W-1:0]  en,
    input logic [W-1:0]  stat,
    input logic [W-1:0]  lat,
    input logic [W-1:0]  clr,
    input logic [7:0]    rd_data,
    input logic          fault_o
);
    assert_src_fault_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((en & stat) != '0) |=> fault_o);

    assert_no_spurious_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((lat & ~$past(lat) & ~$past(en & stat)) == '0));

    assert_latch_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((lat & $past(lat & ~clr)) == $past(lat & ~clr)));

    assert_fault_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault_o) |-> $past(wr_vld && !start_vld));

    assert_ptr_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr == '1 && (wr_vld || rd_vld) && !start_vld) |=> (ptr == '0));

    assert_ptr_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_vld |=> (ptr == $past(start_ofs)));

    assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_vld && !wr_vld && !start_vld) |=> $stable(rd_data));
endmodule

bind diag_irq_bank diag_irq_bank_chk #(.AW(AW), .W(2 * ((N_COND + 7) / 8) * 8)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_vld (start_vld),
    .start_ofs (start_ofs),
    .wr_vld    (wr_vld),
    .rd_vld    (rd_vld),
    .ptr       (ptr),
    .en        (en_q),
    .stat      (stat_b),
    .lat       (lat_q),
    .clr       (clr_b),
    .rd_data   (rd_data),
    .fault_o   (fault_o)
);

// File: tb/diag_irq_bank_test.sv
`timescale 1ns/1ps
// Bench: directed corner cases plus seeded random traffic, checked against
// a behavioural model written from the requirements.
module diag_irq_bank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] alarm_stat = '0;
    logic [15:0] warn_stat = '0;
    logic        start_vld = 1'b0;
    logic [7:0]  start_ofs = '0;
    logic        wr_vld = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        rd_vld = 1'b0;
    logic [7:0]  rd_data;
    logic        fault_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    logic [7:0] m_en [4];
    logic [7:0] m_lat [4];
    logic [7:0] m_ptr;
    logic [7:0] m_rd;

    always #10 clk = ~clk;

    diag_irq_bank uut (
        .clk(clk), .rst_n(rst_n), .alarm_stat(alarm_stat), .warn_stat(warn_stat),
        .start_vld(start_vld), .start_ofs(start_ofs), .wr_vld(wr_vld),
        .wr_data(wr_data), .rd_vld(rd_vld), .rd_data(rd_data), .fault_o(fault_o)
    );

    function automatic logic [7:0] mask_of(int k);
        return (k % 2 == 1) ? 8'hC0 : 8'hFF;
    endfunction

    function automatic logic [7:0] stat_of(int k);
        case (k)
            0: return alarm_stat[15:8];
            1: return alarm_stat[7:0];
            2: return warn_stat[15:8];
            default: return warn_stat[7:0];
        endcase
    endfunction

    function automatic logic [7:0] read_of(logic [7:0] ofs);
        if (ofs >= 8'd248 && ofs <= 8'd251) return m_en[ofs - 8'd248];
        if (ofs >= 8'd252) return m_lat[ofs - 8'd252];
        return 8'h00;
    endfunction

    function automatic logic exp_fault();
        return (m_lat[0] | m_lat[1] | m_lat[2] | m_lat[3]) != 8'h00;
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // One clock: drive at negedge, advance the model, compare at next negedge.
    task automatic cyc(logic s, logic [7:0] so, logic w, logic [7:0] wd, logic r);
        logic [7:0] nen [4];
        logic [7:0] nlat [4];
        logic [7:0] clr;
        logic aw, ar;
        start_vld = s; start_ofs = so; wr_vld = w; wr_data = wd; rd_vld = r;
        aw = w && !s;
        ar = r && !w && !s;
        for (int k = 0; k < 4; k++) begin
            clr = (aw && m_ptr == 8'(252 + k)) ? wd : 8'h00;
            nlat[k] = ((m_lat[k] & ~clr) | (m_en[k] & stat_of(k))) & mask_of(k);
            nen[k]  = (aw && m_ptr == 8'(248 + k)) ? (wd & mask_of(k)) : m_en[k];
        end
        if (ar) m_rd = read_of(m_ptr);
        if (s) m_ptr = so;
        else if (aw || ar) m_ptr = m_ptr + 8'd1;
        for (int k = 0; k < 4; k++) begin
            m_en[k] = nen[k];
            m_lat[k] = nlat[k];
        end
        @(posedge clk);
        @(negedge clk);
        start_vld = 0; wr_vld = 0; rd_vld = 0;
        check("R6 fault", {7'd0, fault_o}, {7'd0, exp_fault()});
        check("R10 rd_data", rd_data, m_rd);
    endtask

    task automatic wr_at(logic [7:0] ofs, logic [7:0] d);
        cyc(1, ofs, 0, 0, 0);
        cyc(0, 0, 1, d, 0);
    endtask

    task automatic rd_at(string tag, logic [7:0] ofs, logic [7:0] exp);
        cyc(1, ofs, 0, 0, 0);
        cyc(0, 0, 0, 0, 1);
        check(tag, rd_data, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 4; k++) begin m_en[k] = 0; m_lat[k] = 0; end
        m_ptr = 0; m_rd = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 fault after reset", {7'd0, fault_o}, 8'h00);
        check("R1 rd_data after reset", rd_data, 8'h00);
        for (int o = 248; o < 256; o++) rd_at("R1 bank clear", 8'(o), 8'h00);

        // R2 layout and reserved masking
        wr_at(248, 8'hFF);
        wr_at(249, 8'hFF);
        rd_at("R2 alarm en byte0", 248, 8'hFF);
        rd_at("R2 reserved masked", 249, 8'hC0);

        // R3 temperature high alarm (byte 112 bit 7)
        alarm_stat = 16'h8000;
        cyc(0, 0, 0, 0, 0);
        check("R3 fault set", {7'd0, fault_o}, 8'h01);
        rd_at("R3 latch 252", 252, 8'h80);

        // R4 hold, and no latch without enable
        alarm_stat = 16'h0000;
        wr_at(248, 8'h00);
        rd_at("R4 latch holds", 252, 8'h80);
        warn_stat = 16'hFFFF;
        cyc(0, 0, 0, 0, 0);
        warn_stat = 16'h0000;
        rd_at("R4 disabled warn byte0", 254, 8'h00);
        rd_at("R4 disabled warn byte1", 255, 8'h00);

        // R5 write-1-to-clear
        wr_at(252, 8'h00);
        rd_at("R5 zero write no effect", 252, 8'h80);
        wr_at(252, 8'h80);
        check("R6 fault falls", {7'd0, fault_o}, 8'h00);
        rd_at("R5 cleared", 252, 8'h00);

        // R5 re-evaluation: rx power low alarm (byte 113 bit 6) stays active
        alarm_stat = 16'h0040;
        cyc(0, 0, 0, 0, 0);
        wr_at(253, 8'h40);
        rd_at("R5 re-evaluated", 253, 8'h40);
        check("R6 fault held", {7'd0, fault_o}, 8'h01);
        alarm_stat = 16'h0000;
        wr_at(253, 8'hFF);
        rd_at("R5 cleared after drop", 253, 8'h00);
        check("R6 fault low", {7'd0, fault_o}, 8'h00);

        // R2 reserved flag bits never latch
        alarm_stat = 16'h003F;
        cyc(0, 0, 0, 0, 0);
        alarm_stat = 16'h0000;
        rd_at("R2 reserved no latch", 253, 8'h00);

        // R8 unimplemented offsets
        wr_at(8'h10, 8'hAA);
        rd_at("R8 reads zero", 8'h10, 8'h00);
        rd_at("R8 enables untouched", 249, 8'hC0);

        // R7 burst wrap: 255, 0..247 ignored, then byte 250 hits offset 248
        cyc(1, 255, 0, 0, 0);
        for (int i = 0; i < 249; i++) cyc(0, 0, 1, 8'h00, 0);
        cyc(0, 0, 1, 8'h5A, 0);
        rd_at("R7 wrap lands on 248", 248, 8'h5A);
        cyc(1, 250, 0, 0, 0);
        cyc(0, 0, 1, 8'h12, 0);
        cyc(0, 0, 1, 8'hF4, 0);
        cyc(1, 250, 0, 0, 0);
        cyc(0, 0, 0, 0, 1);
        check("R7 burst read 250", rd_data, 8'h12);
        cyc(0, 0, 0, 0, 1);
        check("R7 burst read 251", rd_data, 8'hC0);

        // R9 priority
        cyc(1, 248, 1, 8'h77, 1);
        cyc(0, 0, 0, 0, 1);
        check("R9 start beats write", rd_data, 8'h5A);
        cyc(0, 0, 1, 8'h00, 1);
        check("R9 write beats read", rd_data, 8'h5A);
        rd_at("R9 write took effect", 249, 8'h00);

        // Random traffic against the model
        void'($urandom(32'd1234));
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] so;
            so = ($urandom % 4 == 0) ? 8'($urandom) : 8'(248 + $urandom % 8);
            if ($urandom % 6 == 0) alarm_stat = 16'($urandom) & 16'($urandom);
            if ($urandom % 6 == 0) warn_stat  = 16'($urandom) & 16'($urandom);
            cyc($urandom % 8 == 0, so, $urandom % 3 == 0, 8'($urandom), $urandom % 2 == 0);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule